// File: doc/BRIEF.md
# Block-Parallel Feedforward Equalizer

This block is a finite-impulse-response equalizer that works on a whole block of consecutive symbol-rate samples in each clock. Every accepted clock carries LANES samples x(Lk) through x(Lk+L-1), and the block returns the LANES filtered values y(Lk) through y(Lk+L-1). A serial stream is therefore filtered at a clock that is LANES times slower than the symbol rate. With the default eight lanes, the clock runs at one eighth of the symbol rate. Each output is y(n) = sum over j of c_j * x(n-j), for j from 0 to TAPS-1. Taps that reach back past the start of the current block take their samples from a single history register. That register holds the newest TAPS-1 samples of earlier accepted blocks.

The coefficients load one tap at a time through a write port into a staging bank. A two-state controller moves the staging bank into the live bank in one step. The controller has two states. BANK_CLEAN means no write is pending. BANK_LOADING means a write burst is in progress. The transition CLEAN to LOADING happens on any clock with the write enable high. The transition LOADING to CLEAN, called the commit, happens on the first clock with the write enable low, and the live bank takes the staged values on that edge. A burst of writes therefore changes the filter atomically, at a block boundary.

The full-precision sums are registered, then rounded and saturated into a second register. Results appear two clocks after the block that produced them.

Top module: `ffe_block_par`

## Requirements
- R1: While in_valid is high, lane m of the output equals round_sat(sum over j of c_j * x(Lk+m-j)), computed with the live coefficients of the clock in which the block was accepted.
- R2: Lane m of in_samples is bits [m*SAMP_W +: SAMP_W] and holds x(Lk+m). Lane 0 is the oldest sample. out_samples uses the same lane order with OUT_W-bit fields. All fields are two's complement.
- R3: Samples before the current block come from earlier accepted blocks. After reset those samples are zero.
- R4: A clock with in_valid low is ignored. The history is unchanged, and no output is produced for it.
- R5: out_valid is high exactly two clocks after each clock with in_valid high, and low otherwise.
- R6: Rounding adds 2^(RND_SHIFT-1) to the sum and then shifts it arithmetically right by RND_SHIFT. With the default RND_SHIFT of 4, a sum of 8 gives 1, 7 gives 0, -8 gives 0 and -9 gives -1.
- R7: The rounded value saturates to the range -2^(OUT_W-1) to 2^(OUT_W-1)-1. With the default OUT_W of 10, that range is -512 to 511.
- R8: Writes go to the staging bank. The live bank does not change while coef_we is high. It takes the staged values at the end of the first clock with coef_we low after a write (the LOADING to CLEAN transition). Blocks accepted up to and including that clock use the old coefficients.
- R9: Reset clears both coefficient banks, the history, out_valid and out_samples to zero.
- R10: coef_addr value j selects tap c_j, the weight of x(n-j).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is present on in_samples |
| in_samples | input | LANES*SAMP_W | Block of signed samples, lane 0 oldest |
| coef_we | input | 1 | Write one tap into the staging bank |
| coef_addr | input | $clog2(TAPS) | Tap index j |
| coef_data | input | COEF_W | Signed tap value |
| out_valid | output | 1 | A result block is present on out_samples |
| out_samples | output | LANES*OUT_W | Rounded, saturated results, lane 0 first |

## Verification
The bench builds two instances. The first has eight lanes and eight taps. The second has four lanes and four taps. Both are compared lane by lane against a serial reference filter fed the same stream. The eight-lane build exercises taps that cross the block boundary from every lane position. The four-lane build makes the history span nearly a whole block, so every lane but the last reaches into the previous block. Both builds also run: saturation at both rails, the rounding steps around half an LSB, blocks accepted during and right after a coefficient burst, and idle clocks that carry garbage samples.

// File: rtl/ffe_pkg.sv
package ffe_pkg;
    localparam int unsigned DEF_SAMP_W    = 6;
    localparam int unsigned DEF_COEF_W    = 8;
    localparam int unsigned DEF_OUT_W     = 10;
    localparam int unsigned DEF_RND_SHIFT = 4;

    typedef enum logic {
        BANK_CLEAN   = 1'b0,
        BANK_LOADING = 1'b1
    } bank_state_t;
endpackage

// File: rtl/ffe_coef_bank.sv
module ffe_coef_bank
    import ffe_pkg::*;
#(
    parameter int unsigned TAPS   = 8,
    parameter int unsigned COEF_W = 8,
    parameter int unsigned ADDR_W = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [COEF_W-1:0]        wr_data,
    output logic [TAPS*COEF_W-1:0]   coef_live
);
    bank_state_t st_q, st_d;
    logic        commit;
    logic [TAPS*COEF_W-1:0] staged_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BANK_CLEAN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        unique case (st_q)
            BANK_CLEAN:   if (wr_en) st_d = BANK_LOADING;
            BANK_LOADING: if (!wr_en) begin
                              st_d   = BANK_CLEAN;
                              commit = 1'b1;
                          end
            default:      st_d = BANK_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q  <= '0;
            coef_live <= '0;
        end else begin
            if (wr_en && (32'(wr_addr) < TAPS))
                staged_q[wr_addr*COEF_W +: COEF_W] <= wr_data;
            if (commit)
                coef_live <= staged_q;
        end
    end

    // R8: the live bank is frozen during a write burst
    a_r8_hold_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BANK_LOADING && wr_en) |=> $stable(coef_live));

    // R8: no pending burst means no change of the live bank
    a_r8_clean_is_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BANK_CLEAN) |=> $stable(coef_live));

    // R8: the commit edge copies the staged taps
    a_r8_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BANK_LOADING && !wr_en) |=> (coef_live == staged_q && st_q == BANK_CLEAN));
endmodule

// File: rtl/ffe_lane_mac.sv
module ffe_lane_mac #(
    parameter int unsigned TAPS   = 8,
    parameter int unsigned SAMP_W = 6,
    parameter int unsigned COEF_W = 8,
    parameter int unsigned ACC_W  = SAMP_W + COEF_W + $clog2(TAPS)
) (
    input  logic [TAPS*SAMP_W-1:0]   win,
    input  logic [TAPS*COEF_W-1:0]   coef,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int unsigned PROD_W = SAMP_W + COEF_W;

    always_comb begin
        logic signed [PROD_W-1:0] prod;
        acc = '0;
        for (int j = 0; j < TAPS; j++) begin
            prod = $signed(win[j*SAMP_W +: SAMP_W]) * $signed(coef[j*COEF_W +: COEF_W]);
            acc  = acc + $signed({{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod});
        end
    end
endmodule

// File: rtl/ffe_round_sat.sv
module ffe_round_sat #(
    parameter int unsigned IN_W  = 17,
    parameter int unsigned OUT_W = 10,
    parameter int unsigned SHIFT = 4
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int unsigned RW = IN_W + 1;
    localparam logic signed [RW-1:0] HALF = RW'(1 << (SHIFT - 1));
    localparam logic signed [RW-1:0] HI   = RW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [RW-1:0] LO   = RW'(-(1 << (OUT_W - 1)));

    logic signed [RW-1:0] biased, shifted;

    always_comb begin
        biased  = $signed({din[IN_W-1], din}) + HALF;
        shifted = biased >>> SHIFT;
        if (shifted > HI)      dout = HI[OUT_W-1:0];
        else if (shifted < LO) dout = LO[OUT_W-1:0];
        else                   dout = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/ffe_block_par.sv
module ffe_block_par
    import ffe_pkg::*;
#(
    parameter int unsigned LANES     = 8,
    parameter int unsigned TAPS      = 8,
    parameter int unsigned SAMP_W    = DEF_SAMP_W,
    parameter int unsigned COEF_W    = DEF_COEF_W,
    parameter int unsigned OUT_W     = DEF_OUT_W,
    parameter int unsigned RND_SHIFT = DEF_RND_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*SAMP_W-1:0]   in_samples,
    input  logic                      coef_we,
    input  logic [$clog2(TAPS)-1:0]   coef_addr,
    input  logic [COEF_W-1:0]         coef_data,
    output logic                      out_valid,
    output logic [LANES*OUT_W-1:0]    out_samples
);
    localparam int unsigned HIST   = TAPS - 1;
    localparam int unsigned EXT_N  = LANES + HIST;
    localparam int unsigned ADDR_W = $clog2(TAPS);
    localparam int unsigned ACC_W  = SAMP_W + COEF_W + $clog2(TAPS);

    logic [TAPS*COEF_W-1:0]  coef_live;
    logic [HIST*SAMP_W-1:0]  hist_q;
    logic [EXT_N*SAMP_W-1:0] ext;
    logic signed [ACC_W-1:0] acc_c [LANES];
    logic signed [ACC_W-1:0] acc_q [LANES];
    logic [LANES*OUT_W-1:0]  rnd_flat;
    logic                    v1_q;

    ffe_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (coef_we),
        .wr_addr   (coef_addr),
        .wr_data   (coef_data),
        .coef_live (coef_live)
    );

    // ext sample i is x(Lk + i - HIST); the oldest history sample sits at index 0
    assign ext = {in_samples, hist_q};

    for (genvar m = 0; m < LANES; m++) begin : g_lane
        logic [TAPS*SAMP_W-1:0] win;
        for (genvar j = 0; j < TAPS; j++) begin : g_tap
            assign win[j*SAMP_W +: SAMP_W] = ext[(m + HIST - j)*SAMP_W +: SAMP_W];
        end
        ffe_lane_mac #(.TAPS(TAPS), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
            .win  (win),
            .coef (coef_live),
            .acc  (acc_c[m])
        );
        ffe_round_sat #(.IN_W(ACC_W), .OUT_W(OUT_W), .SHIFT(RND_SHIFT)) u_rs (
            .din  (acc_q[m]),
            .dout (rnd_flat[m*OUT_W +: OUT_W])
        );
    end

    // stage 1: history update and full-precision sums
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q   <= 1'b0;
            hist_q <= '0;
            for (int m = 0; m < LANES; m++) acc_q[m] <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                hist_q <= ext[EXT_N*SAMP_W-1 -: HIST*SAMP_W];
                for (int m = 0; m < LANES; m++) acc_q[m] <= acc_c[m];
            end
        end
    end

    // stage 2: rounded and saturated results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_samples <= '0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) out_samples <= rnd_flat;
        end
    end

    // R5: every accepted block yields a result two clocks later
    a_r5_latency_hi: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R5: an idle clock yields no result
    a_r5_latency_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R4: the history is held across idle clocks
    a_r4_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hist_q));

    // R4: the result register is held when no sums arrive
    a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !v1_q |=> $stable(out_samples));
endmodule

// File: tb/sim_ffe_block_par.sv
module ffe_bench_core #(
    parameter int L = 8,
    parameter int N = 8
) (
    input  logic clk,
    output int   n_chk,
    output int   n_bad,
    output logic done
);
    localparam int SW = 6, CW = 8, OW = 10, SH = 4, AW = $clog2(N);

    logic rst_n, in_valid, coef_we, out_valid;
    logic [L*SW-1:0] in_samples;
    logic [AW-1:0]   coef_addr;
    logic [CW-1:0]   coef_data;
    logic [L*OW-1:0] out_samples;

    ffe_block_par #(.LANES(L), .TAPS(N), .SAMP_W(SW), .COEF_W(CW), .OUT_W(OW), .RND_SHIFT(SH)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_samples(out_samples)
    );

    int cyc = 0;
    int ref_act[N], ref_stg[N], ref_line[N], blk[L], cset[N];
    bit pend, mon_on;
    logic [L*OW-1:0] exp_q[$];
    int    due_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_rs(int a);
        int t;
        t = (a + (1 << (SH - 1))) >>> SH;
        if (t > 511)  t = 511;
        if (t < -512) t = -512;
        return t;
    endfunction

    task automatic step(bit v, bit we, int addr, int data, string tag);
        logic [L*OW-1:0] e;
        int acc;
        in_valid  = v;
        coef_we   = we;
        coef_addr = AW'(addr);
        coef_data = CW'(data);
        for (int i = 0; i < L; i++) in_samples[i*SW +: SW] = SW'(blk[i]);
        if (v) begin
            for (int i = 0; i < L; i++) begin
                for (int j = N - 1; j > 0; j--) ref_line[j] = ref_line[j-1];
                ref_line[0] = blk[i];
                acc = 0;
                for (int j = 0; j < N; j++) acc += ref_act[j] * ref_line[j];
                e[i*OW +: OW] = OW'(ref_rs(acc));
            end
            exp_q.push_back(e);
            due_q.push_back(cyc + 2);
            tag_q.push_back(tag);
        end
        if (we) begin
            ref_stg[addr] = data;
            pend = 1;
        end else if (pend) begin
            ref_act = ref_stg;
            pend = 0;
        end
        @(negedge clk);
    endtask

    task automatic rand_blk();
        for (int i = 0; i < L; i++) blk[i] = int'($urandom_range(63)) - 32;
    endtask

    task automatic fill_blk(int val);
        for (int i = 0; i < L; i++) blk[i] = val;
    endtask

    task automatic load_coefs();
        for (int t = 0; t < N; t++) step(0, 1, t, cset[t], "");
        step(0, 0, 0, 0, "");
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R4 R5 (L=%0d): got unexpected output at cycle %0d, expected none", L, cyc);
                end else begin
                    logic [L*OW-1:0] e;
                    int d;
                    string t;
                    bit bad;
                    e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
                    n_chk++;
                    bad = 0;
                    if (d != cyc) begin
                        bad = 1;
                        $display("FAIL R5 (L=%0d): got result at cycle %0d, expected %0d", L, cyc, d);
                    end
                    for (int i = 0; i < L; i++)
                        if (out_samples[i*OW +: OW] !== e[i*OW +: OW]) begin
                            bad = 1;
                            $display("FAIL %s (L=%0d) lane %0d: got %0d, expected %0d", t, L, i,
                                     $signed(out_samples[i*OW +: OW]), $signed(e[i*OW +: OW]));
                        end
                    if (bad) n_bad++;
                end
            end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
                n_chk++; n_bad++;
                $display("FAIL R5 (L=%0d): got no output at cycle %0d, expected one due at %0d", L, cyc, due_q[0]);
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        n_chk = 0; n_bad = 0; done = 0; pend = 0; mon_on = 0;
        rst_n = 0; in_valid = 0; coef_we = 0; coef_addr = '0; coef_data = '0; in_samples = '0;
        for (int j = 0; j < N; j++) begin ref_act[j] = 0; ref_stg[j] = 0; ref_line[j] = 0; end
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        n_chk++;
        if (out_valid !== 1'b0 || out_samples !== '0) begin
            n_bad++;
            $display("FAIL R9 (L=%0d): got valid=%0b data=%0h, expected 0 and 0", L, out_valid, out_samples);
        end
        rst_n = 1; mon_on = 1;
        @(negedge clk);
        // R9: cleared coefficients give zero outputs
        for (int k = 0; k < 3; k++) begin rand_blk(); step(1, 0, 0, 0, "R9"); end
        // R1 R3: random taps, random stream across block boundaries
        for (int t = 0; t < N; t++) cset[t] = int'($urandom_range(255)) - 128;
        load_coefs();
        for (int k = 0; k < 40; k++) begin rand_blk(); step(1, 0, 0, 0, "R1 R3"); end
        // R4: idle clocks with garbage samples change nothing
        for (int k = 0; k < 3; k++) begin rand_blk(); step(0, 0, 0, 0, ""); end
        for (int k = 0; k < 5; k++) begin rand_blk(); step(1, 0, 0, 0, "R4"); end
        // R2: distinct value per lane
        for (int i = 0; i < L; i++) blk[i] = i * 3 - 10;
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        // R10: single tap c_(N/2) selects the sample N/2 back
        for (int t = 0; t < N; t++) cset[t] = 0;
        cset[N/2] = 64;
        load_coefs();
        fill_blk(0); blk[0] = 20; step(1, 0, 0, 0, "R10");
        fill_blk(0); blk[L-1] = -17; step(1, 0, 0, 0, "R10");
        fill_blk(0); step(1, 0, 0, 0, "R10");
        // R6: rounding around half an output LSB
        for (int t = 0; t < N; t++) cset[t] = 0;
        cset[0] = 1;
        load_coefs();
        begin
            int pat[8] = '{8, 7, -8, -9, 24, 23, -24, -25};
            for (int i = 0; i < L; i++) blk[i] = pat[i];
            step(1, 0, 0, 0, "R6");
        end
        // R7: saturation at both rails
        for (int t = 0; t < N; t++) cset[t] = 127;
        load_coefs();
        fill_blk(31);  step(1, 0, 0, 0, "R7"); step(1, 0, 0, 0, "R7");
        fill_blk(-32); step(1, 0, 0, 0, "R7"); step(1, 0, 0, 0, "R7");
        for (int t = 0; t < N; t++) cset[t] = -128;
        load_coefs();
        step(1, 0, 0, 0, "R7"); step(1, 0, 0, 0, "R7");
        // R8: blocks during a burst and in the commit clock use the old taps
        for (int t = 0; t < N; t++) begin
            rand_blk();
            step(1, 1, t, int'($urandom_range(255)) - 128, "R8");
        end
        rand_blk(); step(1, 0, 0, 0, "R8");
        for (int k = 0; k < 3; k++) begin rand_blk(); step(1, 0, 0, 0, "R8"); end
        for (int k = 0; k < 10; k++) begin rand_blk(); step(1, 0, 0, 0, "R1"); end
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, "");
        done = 1;
    end
endmodule

module sim_ffe_block_par;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int   c8, b8, c4, b4;
    logic d8, d4;

    ffe_bench_core #(.L(8), .N(8)) c_wide   (.clk(clk), .n_chk(c8), .n_bad(b8), .done(d8));
    ffe_bench_core #(.L(4), .N(4)) c_narrow (.clk(clk), .n_chk(c4), .n_bad(b4), .done(d4));

    initial begin
        int cycles;
        int tot_c, tot_b;
        cycles = 0;
        while (!(d8 === 1'b1 && d4 === 1'b1) && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        @(negedge clk);
        tot_c = c8 + c4;
        tot_b = b8 + b4;
        if (!(d8 === 1'b1 && d4 === 1'b1)) begin
            tot_c++; tot_b++;
            $display("FAIL R5 watchdog: got no completion after %0d cycles, expected completion", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==", tot_c, tot_b);
        $finish;
    end
endmodule